// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two 32-bit operands over several clock cycles and returns a 64-bit product as an upper word and a lower word. One 32-bit adder is reused on every step. The multiplicand sits in a register that never moves. A single double-width product register starts with the multiplier in its lower half. On each step the lowest bit of that register decides whether the multiplicand is added into the upper half, and then the whole register moves one place to the right.

A caller raises `start_i` for one cycle while the block is idle, with the operands and the mode bit valid. `busy_o` stays high while the operation runs. `done_o` pulses for one cycle when the product is final. In signed mode both operands are first reduced to their magnitudes. The main loop covers the 31 magnitude bits below the sign position. A single alignment step then consumes the top magnitude bit, which is set only for the most negative input. The 64-bit result is negated at the end when exactly one operand was negative.

Top module: `seq_mult`

## Requirements
- R1: While reset is low and in the first cycle after it, `busy_o` and `done_o` are 0 and `hi_o`/`lo_o` are 0.
- R2: A high `start_i` sampled while `busy_o` is 0 starts an operation, and `busy_o` is 1 from the next cycle.
- R3: `done_o` is high for exactly one cycle, WIDTH+1 (33) cycles after the edge that accepted `start_i`, and `busy_o` is 0 in that cycle.
- R4: With `signed_i` = 0 the operands are unsigned and `{hi_o, lo_o}` equals their full 64-bit product when `done_o` is high.
- R5: With `signed_i` = 1 the operands are two's complement and `{hi_o, lo_o}` equals their two's-complement 64-bit product.
- R6: In signed mode, an operand of 0x80000000 is treated as -2^31, including when both operands have that value (the product is then 2^62).
- R7: A `start_i` raised while `busy_o` is 1 has no effect: the running operation completes with its own operands and latency, and no extra `done_o` pulse follows.
- R8: After `done_o`, `hi_o` and `lo_o` keep the product until the next accepted start.
- R9: `hi_o` carries product bits 63..32 and `lo_o` carries bits 31..0.
- R10: The carry out of the adder is kept on every step, so 0xFFFFFFFF x 0xFFFFFFFF unsigned gives 0xFFFFFFFE_00000001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin an operation when idle |
| signed_i | input | 1 | 1 = two's complement operands, 0 = unsigned |
| mcand_i | input | 32 | Multiplicand |
| mplier_i | input | 32 | Multiplier |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse: product final |
| hi_o | output | 32 | Upper product word |
| lo_o | output | 32 | Lower product word |

## Verification
The bench targets the all-ones unsigned square. A design that drops the adder carry returns a wrong upper word for it. It also targets the most negative signed value as either operand and as both. A design that skips the top magnitude bit returns zero for these, and one that negates at the wrong time returns the wrong sign. Start pulses are raised in the middle of a run. A design that accepts them restarts with the wrong operands or emits an extra done. Back-to-back operations launched in the done cycle, and a long idle stretch after completion, catch latency that is off by a cycle and a result that drifts before the next start.

// File: rtl/smul_pkg.sv
package smul_pkg;
    typedef enum logic [1:0] {
        SM_IDLE  = 2'd0,
        SM_RUN   = 2'd1,
        SM_ALIGN = 2'd2,
        SM_FIN   = 2'd3
    } smul_state_e;
endpackage

// File: rtl/smul_abs.sv
// Magnitude of an operand; the most negative value maps to 2^(W-1) unsigned.
module smul_abs #(
    parameter int W = 32
) (
    input  logic [W-1:0] val_i,
    input  logic         sgn_i,
    output logic [W-1:0] mag_o,
    output logic         neg_o
);
    always_comb begin
        neg_o = sgn_i & val_i[W-1];
        mag_o = neg_o ? (~val_i + W'(1)) : val_i;
    end
endmodule

// File: rtl/smul_step.sv
// One iteration: conditional add into the upper half, then shift right by one.
module smul_step #(
    parameter int W = 32
) (
    input  logic [2*W-1:0] prod_i,
    input  logic [W-1:0]   mcand_i,
    output logic [2*W-1:0] prod_o
);
    logic [W:0] sum;
    always_comb begin
        sum    = {1'b0, prod_i[2*W-1:W]} + {1'b0, (prod_i[0] ? mcand_i : '0)};
        prod_o = {sum, prod_i[W-1:1]};
    end
endmodule

// File: rtl/smul_neg.sv
module smul_neg #(
    parameter int PW = 64
) (
    input  logic [PW-1:0] val_i,
    input  logic          en_i,
    output logic [PW-1:0] val_o
);
    always_comb val_o = en_i ? (~val_i + PW'(1)) : val_i;
endmodule

// File: rtl/seq_mult.sv
module seq_mult
    import smul_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             signed_i,
    input  logic [WIDTH-1:0] mcand_i,
    input  logic [WIDTH-1:0] mplier_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o
);
    localparam int PW    = 2 * WIDTH;
    localparam int CNT_W = $clog2(WIDTH + 1);
    localparam int NOPS  = 2;

    typedef struct packed {
        smul_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic [WIDTH-1:0] mcand;
        logic [PW-1:0]    prod;
        logic             neg;
        logic             sgn;
        logic             done;
    } regs_t;

    regs_t q, d;

    logic [WIDTH-1:0] op_raw [NOPS];
    logic [WIDTH-1:0] op_mag [NOPS];
    logic             op_neg [NOPS];

    assign op_raw[0] = mcand_i;
    assign op_raw[1] = mplier_i;

    for (genvar g = 0; g < NOPS; g++) begin : g_abs
        smul_abs #(.W(WIDTH)) u_abs (
            .val_i (op_raw[g]),
            .sgn_i (signed_i),
            .mag_o (op_mag[g]),
            .neg_o (op_neg[g])
        );
    end

    logic [PW-1:0] step_prod, fin_prod;

    smul_step #(.W(WIDTH)) u_step (
        .prod_i  (q.prod),
        .mcand_i (q.mcand),
        .prod_o  (step_prod)
    );

    smul_neg #(.PW(PW)) u_neg (
        .val_i (q.prod),
        .en_i  (q.neg),
        .val_o (fin_prod)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            SM_IDLE: begin
                if (start_i) begin
                    d.st    = SM_RUN;
                    d.cnt   = signed_i ? CNT_W'(WIDTH - 1) : CNT_W'(WIDTH);
                    d.mcand = op_mag[0];
                    d.prod  = {{WIDTH{1'b0}}, op_mag[1]};
                    d.neg   = op_neg[0] ^ op_neg[1];
                    d.sgn   = signed_i;
                end
            end
            SM_RUN: begin
                d.prod = step_prod;
                d.cnt  = q.cnt - CNT_W'(1);
                if (q.cnt == CNT_W'(1)) begin
                    d.st = q.sgn ? SM_ALIGN : SM_FIN;
                end
            end
            SM_ALIGN: begin
                // top magnitude bit: set only for the most negative operand
                d.prod = step_prod;
                d.st   = SM_FIN;
            end
            SM_FIN: begin
                d.prod = fin_prod;
                d.st   = SM_IDLE;
                d.done = 1'b1;
            end
            default: d.st = SM_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy_o = (q.st != SM_IDLE);
    assign done_o = q.done;
    assign hi_o   = q.prod[PW-1:WIDTH];
    assign lo_o   = q.prod[WIDTH-1:0];
endmodule

// File: rtl/smul_chk.sv
module smul_chk #(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [WIDTH-1:0] hi_o,
    input logic [WIDTH-1:0] lo_o
);
    localparam int LW = $clog2(WIDTH + 4) + 1;

    // cycles since the accepting edge; equals WIDTH+2 in the done cycle
    logic [LW-1:0] lat;
    always_ff @(posedge clk) begin
        if (!rst_n)                 lat <= '0;
        else if (start_i && !busy_o) lat <= LW'(1);
        else if (busy_o)            lat <= lat + LW'(1);
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !done_o)); // R1
    AST_START_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R3
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R3
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (lat == LW'(WIDTH + 2))); // R3
    AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (busy_o || done_o)); // R7
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable({hi_o, lo_o})); // R8
endmodule

bind seq_mult smul_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .hi_o    (hi_o),
    .lo_o    (lo_o)
);

// File: tb/seq_mult_tb.sv
module seq_mult_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;
    localparam int LATENCY = W + 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         signed_i = 1'b0;
    logic [W-1:0] mcand_i = '0;
    logic [W-1:0] mplier_i = '0;
    logic         busy_o, done_o;
    logic [W-1:0] hi_o, lo_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit finished = 0;

    typedef struct {
        logic [2*W-1:0] exp;
        int             cyc;
        string          req;
    } item_t;
    item_t sbq[$];
    logic [2*W-1:0] last_res = '0;

    seq_mult #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .signed_i(signed_i),
        .mcand_i(mcand_i), .mplier_i(mplier_i), .busy_o(busy_o),
        .done_o(done_o), .hi_o(hi_o), .lo_o(lo_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=0x%016h expected=0x%016h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                                            input logic s);
        logic signed [63:0] sa, sb;
        logic [63:0] p;
        if (s) begin
            sa = {{32{a[31]}}, a};
            sb = {{32{b[31]}}, b};
            p  = sa * sb;
        end else begin
            p = {32'b0, a} * {32'b0, b};
        end
        return p;
    endfunction

    // driver: issues an operation and pushes its expected result
    task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input logic s,
                         input string req);
        item_t it;
        @(negedge clk);
        while (busy_o) @(negedge clk);
        mcand_i  = a;
        mplier_i = b;
        signed_i = s;
        start_i  = 1'b1;
        it.exp = ref_mul(a, b, s);
        it.cyc = cyc + 1;
        it.req = req;
        sbq.push_back(it);
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R2 busy after start", 64'(busy_o), 64'd1);
    endtask

    // monitor: pops and compares on each done pulse
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (sbq.size() == 0) begin
                check(1'b0, "R7 unexpected done", {hi_o, lo_o}, 64'd0);
            end else begin
                item_t it;
                it = sbq.pop_front();
                check({hi_o, lo_o} === it.exp, it.req, {hi_o, lo_o}, it.exp);
                check(cyc - it.cyc == LATENCY, "R3 latency", 64'(cyc - it.cyc),
                      64'(LATENCY));
                check(busy_o == 1'b0, "R3 busy low at done", 64'(busy_o), 64'd0);
                last_res = {hi_o, lo_o};
            end
        end
    end

    task automatic drain();
        int guard = 0;
        while ((sbq.size() != 0 || busy_o) && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy_o == 0 && done_o == 0, "R1 flags in reset", {62'd0, busy_o, done_o}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy_o == 0 && done_o == 0, "R1 flags after reset", {62'd0, busy_o, done_o}, 64'd0);
        check({hi_o, lo_o} == 64'd0, "R1 product after reset", {hi_o, lo_o}, 64'd0);

        issue(32'd3, 32'd5, 1'b0, "R4 small unsigned");
        issue(32'd0, 32'hDEADBEEF, 1'b0, "R4 zero operand");
        issue(32'hFFFFFFFF, 32'd1, 1'b0, "R4 max times one");
        issue(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, "R10 carry all ones");
        issue(32'h00010000, 32'h00010000, 1'b0, "R9 word split");
        issue(-32'sd3, 32'd7, 1'b1, "R5 neg times pos");
        issue(-32'sd3, -32'sd7, 1'b1, "R5 neg times neg");
        issue(32'd5, -32'sd1, 1'b1, "R5 pos times minus one");
        issue(32'h7FFFFFFF, 32'h7FFFFFFF, 1'b1, "R5 max positive square");
        issue(32'h80000000, 32'd1, 1'b1, "R6 min as multiplicand");
        issue(32'd3, 32'h80000000, 1'b1, "R6 min as multiplier");
        issue(32'h80000000, 32'h80000000, 1'b1, "R6 min squared");
        issue(32'h80000000, 32'hFFFFFFFF, 1'b1, "R6 min times minus one");
        issue(32'h80000000, 32'h80000000, 1'b0, "R4 unsigned high bit");
        drain();

        // R7: start raised mid-run must be ignored
        issue(32'd1234, 32'd5678, 1'b0, "R7 first op survives");
        repeat (5) @(negedge clk);
        mcand_i = 32'd9; mplier_i = 32'd9; signed_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        drain();
        repeat (40) @(negedge clk);
        check(sbq.size() == 0, "R7 no extra result", 64'(sbq.size()), 64'd0);

        // R8: result held while idle
        repeat (20) @(negedge clk);
        check({hi_o, lo_o} == last_res, "R8 hold idle", {hi_o, lo_o}, last_res);
        check(last_res == 64'd7006652, "R7 first operands used", last_res, 64'd7006652);

        for (int i = 0; i < 24; i++) begin
            logic [W-1:0] a, b;
            a = $urandom;
            b = $urandom;
            if (i % 4 == 0) a = {1'b1, a[30:0]};
            issue(a, b, 1'(i % 2), (i % 2) ? "R5 random signed" : "R4 random unsigned");
        end
        drain();

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule